// File: doc/BRIEF.md
# Indexed Chipset Configuration Register File

This block is a bank of 39 configuration bytes reached through an index/data pair of ports on an 8-bit I/O bus. Software first writes a register number to the index port, then reads or writes the selected byte through the data port. Only register numbers 0x50 to 0x76 are accepted as an index. After any data access that hits a valid register, the index falls back to zero, so every access has to be preceded by a fresh index write.

One byte (number 0x52) is write-protected and always keeps its reset value. The reset value of byte 0x59 carries a code derived from the installed memory size, which is sampled from a static input while reset is held. Three bits of byte 0x73 drive enable levels for the primary IDE channel, both serial ports and the parallel port. Each of these has a one-cycle change pulse that fires only when a data write actually flips that bit, so downstream logic can re-map the peripheral.

Top module: `cfg_index_regs`

## Requirements
- R1: `busAddr` = 0 selects the index port and `busAddr` = 1 selects the data port; a read of the index port returns the current index on `busRdata` in the cycle of the read strobe.
- R2: An index-port write loads the index only if the written value is in 0x50..0x76 inclusive; any other value leaves the index unchanged.
- R3: A data-port write while the index is outside 0x50..0x76 changes no register and leaves the index unchanged.
- R4: A data-port write with a valid index stores the byte in register number index (offset index − 0x50) at that clock edge, and the index reads 0 afterwards.
- R5: A data-port write to register 0x52 leaves that register at its reset value, and the index still returns to 0.
- R6: A data-port read with a valid index returns the selected byte during the strobe cycle and clears the index to 0 at the edge ending the strobe; with an invalid index it returns 0xFF and the index is unchanged.
- R7: After reset the index is 0 and all registers read 0 except 0x59 = 0x40 OR memory code, 0x61 = 0x09, 0x62 = 0xFF, 0x73 = 0xF0 and 0x76 = 0x01.
- R8: The memory code for `memSizeMb` megabytes is: 0–1:0x00, 2–3:0x01, 4:0x02, 5:0x20, 6–7:0x09, 8–9:0x04, 10–11:0x05, 12–15:0x0B, 16:0x13, 17:0x21, 18–19:0x06, 20–23:0x0D, 24–31:0x0E, 32–35:0x1B, 36–39:0x0F, 40–47:0x17, 48–63:0x1E, 64:0x24, 65–67:0x22, 68 and up:0x24.
- R9: `ideEn`, `serEn` and `parEn` follow bits 6, 5 and 4 of register 0x73, taking a new value in the cycle after the write edge.
- R10: `ideChg`, `serChg` and `parChg` are high for exactly the one cycle after a register 0x73 write whose value flips the matching bit, and stay low for writes that leave the bit unchanged.
- R11: `memSizeMb` is sampled only while `rst` is high; changing it later does not alter register 0x59.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 1 | Port select: 0 index, 1 data |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational |
| memSizeMb | input | 10 | Installed memory in megabytes, static |
| ideEn | output | 1 | Primary IDE channel enable level |
| ideChg | output | 1 | One-cycle pulse when ideEn changes |
| serEn | output | 1 | Serial ports enable level |
| serChg | output | 1 | One-cycle pulse when serEn changes |
| parEn | output | 1 | Parallel port enable level |
| parChg | output | 1 | One-cycle pulse when parEn changes |

## Verification
Read data is combinational, so each read result is due in the same cycle as its strobe and the scoreboard monitor compares it at the falling edge inside that cycle, before the index clear lands on the next rising edge. Register writes, index updates, enable levels and change pulses all settle at the rising edge that samples the write strobe, so their effects are observed through a later read or an enable probe taken at the falling edge of the following cycle, which is the only cycle a change pulse is high. Memory-size codes are checked by resetting with each boundary size and reading register 0x59, and a size change after reset is checked to leave that byte alone.

// File: rtl/cfg_index_pkg.sv
package cfg_index_pkg;

  localparam int REG_COUNT = 39;
  localparam logic [7:0] IDX_BASE = 8'h50;
  localparam logic [7:0] IDX_LAST = IDX_BASE + 8'(REG_COUNT - 1);
  localparam int OFF_W = $clog2(REG_COUNT);
  localparam int MEM_W = 10;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic             wrEn;
    logic [OFF_W-1:0] off;
    logic [7:0]       wdata;
  } bank_stb_t;

  function automatic logic [7:0] memCode(input logic [MEM_W-1:0] mb);
    int unsigned m;
    m = 32'(mb);
    if (m <= 1)       return 8'h00;
    else if (m <= 3)  return 8'h01;
    else if (m == 4)  return 8'h02;
    else if (m == 5)  return 8'h20;
    else if (m <= 7)  return 8'h09;
    else if (m <= 9)  return 8'h04;
    else if (m <= 11) return 8'h05;
    else if (m <= 15) return 8'h0B;
    else if (m == 16) return 8'h13;
    else if (m == 17) return 8'h21;
    else if (m <= 19) return 8'h06;
    else if (m <= 23) return 8'h0D;
    else if (m <= 31) return 8'h0E;
    else if (m <= 35) return 8'h1B;
    else if (m <= 39) return 8'h0F;
    else if (m <= 47) return 8'h17;
    else if (m <= 63) return 8'h1E;
    else if (m >= 65 && m <= 67) return 8'h22;
    else              return 8'h24;
  endfunction

  function automatic logic [7:0] resetByte(input int off, input logic [7:0] code);
    case (off)
      9:       return 8'h40 | code;
      17:      return 8'h09;
      18:      return 8'hFF;
      35:      return 8'hF0;
      38:      return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfg_index_ctrl.sv
module cfg_index_ctrl
  import cfg_index_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWdata,
  input  logic [7:0] rdByte,
  output bank_stb_t  stb,
  output logic [7:0] busRdata,
  output logic [7:0] curIdx
);

  logic [7:0] idxQ;
  logic [7:0] relIdx;
  logic       idxValid;
  logic       wrInWin;
  logic       idxWr;
  logic       dataHit;

  assign relIdx   = idxQ - IDX_BASE;
  assign idxValid = (idxQ >= IDX_BASE) && (idxQ <= IDX_LAST);
  assign wrInWin  = (busWdata >= IDX_BASE) && (busWdata <= IDX_LAST);
  assign idxWr    = busWr && !busAddr;
  assign dataHit  = busAddr && (busWr || busRd) && idxValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      idxQ <= 8'h00;
    end else if (idxWr) begin
      if (wrInWin) idxQ <= busWdata;
    end else if (dataHit) begin
      idxQ <= 8'h00;
    end
  end

  always_comb begin
    stb.wrEn  = busWr && busAddr && idxValid;
    stb.off   = relIdx[OFF_W-1:0];
    stb.wdata = busWdata;
  end

  always_comb begin
    if (!busAddr)      busRdata = idxQ;
    else if (idxValid) busRdata = rdByte;
    else               busRdata = 8'hFF;
  end

  assign curIdx = idxQ;

endmodule

// File: rtl/cfg_index_bank.sv
module cfg_index_bank
  import cfg_index_pkg::*;
#(
  parameter int WP_OFF  = 2,
  parameter int CTL_OFF = 35,
  parameter int CH_N    = 3,
  parameter int CH_BIT [CH_N] = '{6, 5, 4}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MEM_W-1:0] memSizeMb,
  input  bank_stb_t        stb,
  output logic [7:0]       rdByte,
  output logic [CH_N-1:0]  enLvl,
  output logic [CH_N-1:0]  enChg
);

  logic [REG_COUNT-1:0][7:0] bank;
  logic [7:0] sizeCode;
  logic       ctlWr;

  assign sizeCode = memCode(memSizeMb);
  assign ctlWr    = stb.wrEn && (stb.off == OFF_W'(CTL_OFF));

  always_ff @(posedge clk) begin
    for (int i = 0; i < REG_COUNT; i++) begin
      if (rst) begin
        bank[i] <= resetByte(i, sizeCode);
      end else if (stb.wrEn && (stb.off == OFF_W'(i)) && (i != WP_OFF)) begin
        bank[i] <= stb.wdata;
      end
    end
  end

  assign rdByte = bank[stb.off];

  for (genvar k = 0; k < CH_N; k++) begin : g_chan
    assign enLvl[k] = bank[CTL_OFF][CH_BIT[k]];
    always_ff @(posedge clk) begin
      if (rst) enChg[k] <= 1'b0;
      else     enChg[k] <= ctlWr && (stb.wdata[CH_BIT[k]] != bank[CTL_OFF][CH_BIT[k]]);
    end
  end

endmodule

// File: rtl/cfg_index_regs.sv
module cfg_index_regs
  import cfg_index_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [7:0]       busWdata,
  output logic [7:0]       busRdata,
  input  logic [MEM_W-1:0] memSizeMb,
  output logic             ideEn,
  output logic             ideChg,
  output logic             serEn,
  output logic             serChg,
  output logic             parEn,
  output logic             parChg
);

  bank_stb_t  stb;
  logic [7:0] rdByte;
  logic [7:0] curIdx;
  logic [2:0] enLvl;
  logic [2:0] enChg;

  cfg_index_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWdata (busWdata),
    .rdByte   (rdByte),
    .stb      (stb),
    .busRdata (busRdata),
    .curIdx   (curIdx)
  );

  cfg_index_bank #(
    .WP_OFF  (2),
    .CTL_OFF (35),
    .CH_N    (3),
    .CH_BIT  ('{6, 5, 4})
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .memSizeMb (memSizeMb),
    .stb       (stb),
    .rdByte    (rdByte),
    .enLvl     (enLvl),
    .enChg     (enChg)
  );

  assign ideEn  = enLvl[0];
  assign serEn  = enLvl[1];
  assign parEn  = enLvl[2];
  assign ideChg = enChg[0];
  assign serChg = enChg[1];
  assign parChg = enChg[2];

endmodule

// File: rtl/cfg_index_regs_chk.sv
module cfg_index_regs_chk
  import cfg_index_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       busAddr,
  input logic       busWr,
  input logic       busRd,
  input logic [7:0] busWdata,
  input logic [7:0] busRdata,
  input logic [7:0] curIdx,
  input logic       ideEn,
  input logic       ideChg,
  input logic       serEn,
  input logic       serChg,
  input logic       parEn,
  input logic       parChg
);

  logic idxOk;
  logic dataOk;
  assign idxOk  = (curIdx >= IDX_BASE) && (curIdx <= IDX_LAST);
  assign dataOk = (busWdata >= IDX_BASE) && (busWdata <= IDX_LAST);

  // R2
  idx_window_chk: assert property (@(posedge clk) disable iff (rst)
    (busWr && !busAddr && !dataOk) |=> (curIdx == $past(curIdx)));

  // R3
  bad_data_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (busWr && busAddr && !idxOk) |=> $stable(curIdx));

  // R4
  idx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (busAddr && (busWr || busRd) && idxOk) |=> (curIdx == 8'h00));

  // R6
  bad_read_ff_chk: assert property (@(posedge clk) disable iff (rst)
    (busRd && busAddr && !idxOk) |-> (busRdata == 8'hFF));

  // R10
  ide_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ideChg |-> (ideEn != $past(ideEn)));

  // R10
  ser_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    serChg |-> (serEn != $past(serEn)));

  // R10
  par_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    parChg |-> (parEn != $past(parEn)));

  // R9
  ide_level_chk: assert property (@(posedge clk) disable iff (rst)
    !ideChg |-> $stable(ideEn));

endmodule

bind cfg_index_regs cfg_index_regs_chk u_chk (.*);

// File: tb/sim_cfg_index_regs.sv
`timescale 1ns/1ps
module sim_cfg_index_regs;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       busAddr = 1'b0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic [9:0] memSizeMb = 10'd16;
  logic       ideEn, ideChg, serEn, serChg, parEn, parChg;
  logic       probeReq = 1'b0;

  int nChecks = 0;
  int nFail = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
    bit         isProbe;
  } item_t;
  item_t sbq[$];

  always #10 clk = ~clk;

  cfg_index_regs u0 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .memSizeMb(memSizeMb),
    .ideEn(ideEn), .ideChg(ideChg), .serEn(serEn), .serChg(serChg),
    .parEn(parEn), .parChg(parChg)
  );

  // Monitor: compares results in the cycle they are due
  initial begin
    forever begin
      @(negedge clk);
      if (busRd || probeReq) begin
        logic [7:0] act;
        item_t it;
        act = probeReq ? {2'b00, ideEn, serEn, parEn, ideChg, serChg, parChg} : busRdata;
        nChecks++;
        if (sbq.size() == 0) begin
          nFail++;
          $display("FAIL scoreboard empty: actual %02h expected none", act);
        end else begin
          it = sbq.pop_front();
          if (act !== it.exp) begin
            nFail++;
            $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
          end
        end
      end
    end
  end

  function automatic logic [7:0] benchCode(input int mb);
    int lim [19] = '{1, 3, 4, 5, 7, 9, 11, 15, 16, 17, 19, 23, 31, 35, 39, 47, 63, 64, 67};
    logic [7:0] cd [19] = '{8'h00, 8'h01, 8'h02, 8'h20, 8'h09, 8'h04, 8'h05, 8'h0B, 8'h13,
                            8'h21, 8'h06, 8'h0D, 8'h0E, 8'h1B, 8'h0F, 8'h17, 8'h1E, 8'h24, 8'h22};
    for (int j = 0; j < 19; j++) if (mb <= lim[j]) return cd[j];
    return 8'h24;
  endfunction

  function automatic logic [7:0] expDefault(input int regNo, input int mb);
    case (regNo)
      8'h59:   return 8'h40 | benchCode(mb);
      8'h61:   return 8'h09;
      8'h62:   return 8'hFF;
      8'h73:   return 8'hF0;
      8'h76:   return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  task automatic doReset(input int mb);
    memSizeMb = 10'(mb);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic wrPort(input bit a, input logic [7:0] d);
    busAddr = a; busWr = 1'b1; busWdata = d;
    @(posedge clk);
    #1 busWr = 1'b0;
  endtask

  task automatic rdPort(input bit a, input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag; it.isProbe = 1'b0;
    sbq.push_back(it);
    busAddr = a; busRd = 1'b1;
    @(posedge clk);
    #1 busRd = 1'b0;
  endtask

  task automatic probe(input logic [5:0] exp, input string tag);
    item_t it;
    it.exp = {2'b00, exp}; it.tag = tag; it.isProbe = 1'b1;
    sbq.push_back(it);
    probeReq = 1'b1;
    @(posedge clk);
    #1 probeReq = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    wrPort(1'b0, idx);
    rdPort(1'b1, exp, tag);
  endtask

  task automatic wrReg(input logic [7:0] idx, input logic [7:0] d);
    wrPort(1'b0, idx);
    wrPort(1'b1, d);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    doReset(16);
    @(posedge clk); #1;

    // R7 R1: index port reads 0 after reset
    rdPort(1'b0, 8'h00, "R7 R1 index after reset");
    // R7: every default
    for (int r = 8'h50; r <= 8'h76; r++) rdReg(8'(r), expDefault(r, 16), "R7 default byte");
    // R9: enables from 0x73 = F0
    probe(6'b111_000, "R9 enables after reset");

    // R2: window edges
    wrPort(1'b0, 8'h4F); rdPort(1'b0, 8'h00, "R2 index 4F rejected");
    wrPort(1'b0, 8'h77); rdPort(1'b0, 8'h00, "R2 index 77 rejected");
    wrPort(1'b0, 8'h50); rdPort(1'b0, 8'h50, "R2 R1 index 50 accepted");
    wrPort(1'b0, 8'h76); rdPort(1'b0, 8'h76, "R2 index 76 accepted");
    wrPort(1'b0, 8'h10); rdPort(1'b0, 8'h76, "R2 index kept after 10");

    // R6: valid read then index cleared
    rdPort(1'b1, 8'h01, "R6 valid read 76");
    rdPort(1'b0, 8'h00, "R6 index cleared by read");
    // R6: invalid read returns FF, index unchanged
    rdPort(1'b1, 8'hFF, "R6 invalid read FF");
    rdPort(1'b0, 8'h00, "R6 index unchanged after invalid read");

    // R3: data write with invalid index
    wrPort(1'b1, 8'hAA);
    rdPort(1'b0, 8'h00, "R3 index unchanged");
    rdReg(8'h50, 8'h00, "R3 reg 50 untouched");

    // R4: valid write
    wrReg(8'h58, 8'h3C);
    rdPort(1'b0, 8'h00, "R4 index cleared by write");
    rdReg(8'h58, 8'h3C, "R4 stored byte");
    wrReg(8'h76, 8'h9D);
    rdReg(8'h76, 8'h9D, "R4 last register");

    // R5: protected register
    wrReg(8'h52, 8'h12);
    rdPort(1'b0, 8'h00, "R5 index cleared");
    rdReg(8'h52, 8'h00, "R5 register kept");

    // R9 R10: side effects of register 0x73
    wrReg(8'h73, 8'hB0);
    probe(6'b011_100, "R10 ide pulse only");
    probe(6'b011_000, "R10 pulse lasts one cycle");
    wrReg(8'h73, 8'h40);
    probe(6'b100_111, "R10 all three flip");
    wrReg(8'h73, 8'h4F);
    probe(6'b100_000, "R10 no pulse when bits same");
    rdReg(8'h73, 8'h4F, "R9 control byte readback");

    // R11: size change after reset ignored
    memSizeMb = 10'd100;
    repeat (2) @(posedge clk); #1;
    rdReg(8'h59, 8'h40 | benchCode(16), "R11 size sampled in reset only");

    // R8: code sweep
    begin
      int sizes [24] = '{0, 1, 2, 4, 5, 6, 8, 10, 12, 16, 17, 18, 20, 24,
                         32, 36, 40, 48, 63, 64, 65, 67, 68, 200};
      foreach (sizes[s]) begin
        doReset(sizes[s]);
        @(posedge clk); #1;
        rdReg(8'h59, 8'h40 | benchCode(sizes[s]), "R8 memory code");
      end
    end

    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule